// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor that reads and writes single words and a slower main memory that moves data one word per beat. The processor address is split into three fields: the word inside a block in the lowest bits, the set index above it, and the tag in the remaining upper bits. Both ways of the indexed set are compared at the same time. A hit is answered from local storage one cycle after the request. No memory traffic takes place on a hit.

On a miss the controller picks a victim line in the indexed set. An invalid line is always taken first. Otherwise the line whose use bit is clear is taken. If the victim holds modified data, its eight words go back to memory as eight write beats. The requested block is then read in as eight read beats. After that, the original request is served as an ordinary hit. A write miss therefore allocates the line, merges the written word after the refill, and marks the line as modified.

Top module: `cache2w_wb`

## Requirements
- R1: Address fields are decoded as follows. Bits [2:0] give the word inside the block, bits [6:3] give the set index, and bits [15:7] give the tag. Every memory beat carries the address {line tag, set index, beat number}, and the beat numbers run 0 to 7 in rising order.
- R2: A read that hits returns the stored word. `cpu_ready` is high for one cycle, in the cycle after the request is first presented, and `mem_req` stays low throughout.
- R3: A write that hits changes only the cached word. It produces no memory traffic, and the line is marked as modified.
- R4: Any access to a line sets that line's use bit and clears the use bit of the other line in the same set. On a miss where both lines are valid, the line whose use bit is clear is replaced.
- R5: All lines are invalid after reset. On a miss, an invalid line in the indexed set is chosen before any valid line, and way 0 is checked before way 1.
- R6: A modified victim is copied back as eight write beats (`mem_we`=1) before any refill beat. Its data can later be read back from memory unchanged.
- R7: A victim that was not modified is replaced with eight read beats only, with no write beats.
- R8: A write miss refills the whole block first and then merges the written word. The line is left modified, so a later eviction writes the new value back.
- R9: `mem_req` stays high, with a stable address and direction, until `mem_ack` is seen. Each acknowledge completes exactly one beat.
- R10: After reset, `cpu_ready` and `mem_req` are low. `cpu_ready` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_valid | input | 1 | Processor request; held, with its fields, until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high on a read |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | 16 | Beat word address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Beat acknowledge |
| mem_rdata | input | 32 | Refill data, sampled with `mem_ack` |

## Verification
Some rules are checked by the assertions on every cycle. The memory-side handshake must hold steady until it is acknowledged. Beats must start at word 0 and count up in order. A write-back burst must run through all eight words without a gap. `cpu_ready` must be a single pulse and must never overlap memory traffic. Other behaviour is only visible through the bench's scenarios, which it compares against a behavioural model of tags, use bits and memory contents. These scenarios cover which way gets evicted, whether a write-back happens at all, whether a hit is served in one cycle, and whether modified data survives a trip through memory. The scenarios include directed cases for each victim rule, followed by a long mixed run over a few heavily contended sets.

// File: rtl/cache2w_pkg.sv
// Package: shared controller state encoding for the two-way cache.
package cache2w_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } cstate_t;
endpackage

// File: rtl/cache2w_tags.sv
// Tag store: tag, valid, use and modified bits for two ways.
// It compares both ways in parallel and proposes a victim.
// Assumes a touch and an install never happen in the same cycle.
module cache2w_tags #(
    parameter int SET_W = 4,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             hit_o,
    output logic             hit_way_o,
    output logic             vic_way_o,
    output logic [TAG_W-1:0] vic_tag_o,
    output logic             vic_dirty_o,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             touch_dirty,
    input  logic             inst_en,
    input  logic             inst_way
);
    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_r   [2][SETS];
    logic [SETS-1:0]  valid_r [2];
    logic [SETS-1:0]  use_r   [2];
    logic [SETS-1:0]  dirty_r [2];
    logic [1:0]       hit_w;

    for (genvar w = 0; w < 2; w++) begin : g_way
        // Compare this way's tag with the request.
        assign hit_w[w] = valid_r[w][set_i] && (tag_r[w][set_i] == tag_i);

        // Maintain this way's state bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_r[w] <= '0;
                use_r[w]   <= '0;
                dirty_r[w] <= '0;
            end else if (touch_en) begin
                use_r[w][set_i] <= (touch_way == w[0]);
                if (touch_way == w[0] && touch_dirty)
                    dirty_r[w][set_i] <= 1'b1;
            end else if (inst_en && inst_way == w[0]) begin
                valid_r[w][set_i] <= 1'b1;
                dirty_r[w][set_i] <= 1'b0;
            end
        end

        // Tag field has no reset; it is qualified by valid.
        always_ff @(posedge clk) begin
            if (inst_en && inst_way == w[0])
                tag_r[w][set_i] <= tag_i;
        end
    end

    // Report the hit and pick the victim: invalid first, then clear use bit.
    always_comb begin
        hit_o     = |hit_w;
        hit_way_o = hit_w[1];
        if (!valid_r[0][set_i])      vic_way_o = 1'b0;
        else if (!valid_r[1][set_i]) vic_way_o = 1'b1;
        else                         vic_way_o = use_r[0][set_i];
        vic_tag_o   = tag_r[vic_way_o][set_i];
        vic_dirty_o = valid_r[vic_way_o][set_i] && dirty_r[vic_way_o][set_i];
    end
endmodule

// File: rtl/cache2w_data.sv
// Data store: one word per (way, set, word) entry.
// Combinational read, one synchronous write port, no reset.
module cache2w_data #(
    parameter int DATA_W = 32,
    parameter int SET_W  = 4,
    parameter int WORD_W = 3
) (
    input  logic              clk,
    input  logic              way_i,
    input  logic [SET_W-1:0]  set_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W   = 1 + SET_W + WORD_W;
    localparam int ENTRIES = 1 << IDX_W;

    logic [DATA_W-1:0] store_r [ENTRIES];
    logic [IDX_W-1:0]  idx;

    // Flatten the entry coordinates into one index.
    assign idx     = {way_i, set_i, word_i};
    assign rd_data = store_r[idx];

    // Write one word when enabled.
    always_ff @(posedge clk) begin
        if (wr_en) store_r[idx] <= wr_data;
    end
endmodule

// File: rtl/cache2w_ctrl.sv
// Controller: serves hits, sequences write-back and refill bursts.
// Assumes the processor holds its request fields until cpu_ready.
// After a refill it returns to idle, and the request then completes as a hit.
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SET_W  = 4,
    parameter int WORD_W = 3,
    parameter int TAG_W  = 9
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cpu_valid,
    input  logic                            cpu_we,
    input  logic [TAG_W-1:0]                cpu_tag,
    input  logic [SET_W-1:0]                cpu_set,
    input  logic [WORD_W-1:0]               cpu_word,
    output logic                            cpu_ready,
    output logic [DATA_W-1:0]               cpu_rdata,
    output logic                            mem_req,
    output logic                            mem_we,
    output logic [TAG_W+SET_W+WORD_W-1:0]   mem_addr,
    input  logic                            mem_ack,
    input  logic                            hit,
    input  logic                            hit_way,
    input  logic                            vic_way,
    input  logic [TAG_W-1:0]                vic_tag,
    input  logic                            vic_dirty,
    output logic                            touch_en,
    output logic                            inst_en,
    output logic                            acc_way,
    output logic [WORD_W-1:0]               acc_word,
    output logic                            wr_en,
    output logic                            wr_from_mem,
    input  logic [DATA_W-1:0]               rd_data
);
    localparam logic [WORD_W-1:0] LAST_BEAT = '1;

    cstate_t           state;
    logic [WORD_W-1:0] beat;
    logic              vway_q;
    logic [TAG_W-1:0]  vtag_q;
    logic              ready_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept, hit_go, miss_go, fill_ack;

    // Decode the cycle's action and steer the stores.
    always_comb begin
        accept      = (state == ST_IDLE) && cpu_valid && !ready_q;
        hit_go      = accept && hit;
        miss_go     = accept && !hit;
        fill_ack    = (state == ST_FILL) && mem_ack;
        touch_en    = hit_go;
        inst_en     = fill_ack && (beat == LAST_BEAT);
        acc_way     = (state == ST_IDLE) ? hit_way  : vway_q;
        acc_word    = (state == ST_IDLE) ? cpu_word : beat;
        wr_en       = (hit_go && cpu_we) || fill_ack;
        wr_from_mem = (state == ST_FILL);
        mem_req     = (state != ST_IDLE);
        mem_we      = (state == ST_WBACK);
        mem_addr    = {(state == ST_WBACK) ? vtag_q : cpu_tag, cpu_set, beat};
        cpu_ready   = ready_q;
        cpu_rdata   = rdata_q;
    end

    // Completion pulse and captured read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= hit_go;
            if (hit_go) rdata_q <= rd_data;
        end
    end

    // Miss sequencing: optional write-back burst, then refill burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            beat   <= '0;
            vway_q <= 1'b0;
            vtag_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (miss_go) begin
                    vway_q <= vic_way;
                    vtag_q <= vic_tag;
                    beat   <= '0;
                    state  <= vic_dirty ? ST_WBACK : ST_FILL;
                end
                ST_WBACK: if (mem_ack) begin
                    beat <= beat + 1'b1;
                    if (beat == LAST_BEAT) state <= ST_FILL;
                end
                ST_FILL: if (mem_ack) begin
                    beat <= beat + 1'b1;
                    if (beat == LAST_BEAT) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cache2w_wb.sv
// Top: two-way set-associative write-back cache with a word port
// toward the processor and a beat-per-word port toward memory.
// Block size must be a power of two; the address is word granular.
module cache2w_wb #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SET_W  = 4,
    parameter int WORDS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int WORD_W = $clog2(WORDS);
    localparam int TAG_W  = ADDR_W - SET_W - WORD_W;

    logic [WORD_W-1:0] cpu_word, acc_word;
    logic [SET_W-1:0]  cpu_set;
    logic [TAG_W-1:0]  cpu_tag, vic_tag;
    logic              hit, hit_way, vic_way, vic_dirty;
    logic              touch_en, inst_en, acc_way, wr_en, wr_from_mem;
    logic [DATA_W-1:0] rd_data, wr_data;

    // Split the processor address and choose the store write source.
    always_comb begin
        cpu_word  = cpu_addr[WORD_W-1:0];
        cpu_set   = cpu_addr[WORD_W +: SET_W];
        cpu_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
        wr_data   = wr_from_mem ? mem_rdata : cpu_wdata;
        mem_wdata = rd_data;
    end

    cache2w_tags #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .set_i(cpu_set), .tag_i(cpu_tag),
        .hit_o(hit), .hit_way_o(hit_way), .vic_way_o(vic_way),
        .vic_tag_o(vic_tag), .vic_dirty_o(vic_dirty),
        .touch_en(touch_en), .touch_way(hit_way), .touch_dirty(cpu_we),
        .inst_en(inst_en), .inst_way(acc_way)
    );

    cache2w_data #(.DATA_W(DATA_W), .SET_W(SET_W), .WORD_W(WORD_W)) u_data (
        .clk(clk), .way_i(acc_way), .set_i(cpu_set), .word_i(acc_word),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    cache2w_ctrl #(.DATA_W(DATA_W), .SET_W(SET_W), .WORD_W(WORD_W),
                   .TAG_W(TAG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_tag(cpu_tag), .cpu_set(cpu_set), .cpu_word(cpu_word),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .hit(hit), .hit_way(hit_way),
        .vic_way(vic_way), .vic_tag(vic_tag), .vic_dirty(vic_dirty),
        .touch_en(touch_en), .inst_en(inst_en), .acc_way(acc_way),
        .acc_word(acc_word), .wr_en(wr_en), .wr_from_mem(wr_from_mem),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/cache2w_wb_chk.sv
// Checker: port-level protocol properties of the cache, bound to the top.
module cache2w_wb_chk #(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    localparam logic [WORD_W-1:0] LAST = '1;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9
    AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> mem_addr[WORD_W-1:0] == '0); // R1
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_addr[WORD_W-1:0] != LAST
        |=> mem_req && mem_addr[WORD_W-1:0] == $past(mem_addr[WORD_W-1:0]) + 1'b1); // R1
    AST_WB_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack && mem_addr[WORD_W-1:0] != LAST
        |=> mem_req && mem_we); // R6
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack && mem_addr[WORD_W-1:0] == LAST
        |=> mem_req && !mem_we); // R6
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R10
    AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req); // R2
endmodule

bind cache2w_wb cache2w_wb_chk #(.ADDR_W(ADDR_W), .WORD_W($clog2(WORDS))) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/sim_cache2w_wb.sv
// Bench: behavioural model of tags, use bits, the memory image and the
// logical memory value, compared with the design every cycle.
module sim_cache2w_wb;
    localparam int ADDR_W = 16, DATA_W = 32, SET_W = 4, WORDS = 8;
    localparam int SETS = 1 << SET_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_ready, mem_req, mem_we;
    logic [DATA_W-1:0] cpu_rdata, mem_wdata;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // Model state
    int unsigned mtag [2][SETS];
    bit mval [2][SETS], muse [2][SETS], mdirty [2][SETS];
    logic [DATA_W-1:0] backing [int];
    logic [DATA_W-1:0] logical [int];
    int unsigned q_addr [$];
    bit q_we [$];

    always #10 clk = ~clk;

    cache2w_wb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W), .WORDS(WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [DATA_W-1:0] seedval(int a);
        return (a * 32'h0001_0003) ^ 32'hA5A5_0000;
    endfunction
    function automatic logic [DATA_W-1:0] mem_read(int a);
        return backing.exists(a) ? backing[a] : seedval(a);
    endfunction
    function automatic logic [DATA_W-1:0] logic_read(int a);
        return logical.exists(a) ? logical[a] : seedval(a);
    endfunction
    function automatic int mk(int tg, int st, int wd);
        return (tg << 7) | (st << 3) | wd;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory responder: compares every beat against the model's queue.
    always @(negedge clk) begin
        if (mem_ack) mem_ack <= 1'b0;
        else if (mem_req && rst_n) begin
            if (q_addr.size() == 0) begin
                check(0, "R2/R3/R7 unexpected memory beat", {mem_we, mem_addr}, 0);
            end else begin
                check(mem_addr == q_addr[0][ADDR_W-1:0], "R1/R6 beat address", mem_addr, q_addr[0]);
                check(mem_we == q_we[0], "R6/R7 beat direction", mem_we, q_we[0]);
                if (mem_we) backing[int'(mem_addr)] = mem_wdata;
                else mem_rdata <= mem_read(int'(mem_addr));
                void'(q_addr.pop_front());
                void'(q_we.pop_front());
            end
            mem_ack <= 1'b1;
        end
    end

    // Model prediction; returns 1 on hit.
    function automatic bit predict(bit we, int a, logic [DATA_W-1:0] wd);
        int tg = a >> 7, st = (a >> 3) & (SETS - 1), w = -1, v;
        for (int i = 0; i < 2; i++) if (mval[i][st] && mtag[i][st] == tg) w = i;
        predict = (w >= 0);
        if (w < 0) begin
            v = !mval[0][st] ? 0 : (!mval[1][st] ? 1 : (muse[0][st] ? 1 : 0));
            if (mval[v][st] && mdirty[v][st])
                for (int b = 0; b < WORDS; b++) begin
                    q_addr.push_back(mk(mtag[v][st], st, b)); q_we.push_back(1);
                end
            for (int b = 0; b < WORDS; b++) begin
                q_addr.push_back(mk(tg, st, b)); q_we.push_back(0);
            end
            mtag[v][st] = tg; mval[v][st] = 1; mdirty[v][st] = 0;
            w = v;
        end
        muse[w][st] = 1; muse[1-w][st] = 0;
        if (we) begin mdirty[w][st] = 1; logical[a] = wd; end
    endfunction

    task automatic access(bit we, int a, logic [DATA_W-1:0] wd, string req);
        bit exp_hit;
        int cyc = 0;
        logic [DATA_W-1:0] exp_d = logic_read(a);
        @(negedge clk);
        cpu_valid = 1; cpu_we = we; cpu_addr = a[ADDR_W-1:0]; cpu_wdata = wd;
        exp_hit = predict(we, a, wd);
        if (we) exp_d = wd;
        do begin
            @(negedge clk); cyc++;
        end while (!cpu_ready && cyc < 200);
        cpu_valid = 0;
        check(cpu_ready, {req, " completion"}, cyc, 0);
        if (exp_hit) check(cyc == 1, {req, " R2 hit latency"}, cyc, 1);
        else check(cyc > 1, {req, " R4/R5 miss expected"}, cyc, 2);
        if (!we) check(cpu_rdata == exp_d, {req, " read data"}, cpu_rdata, exp_d);
        check(q_addr.size() == 0, {req, " R9 all beats done"}, q_addr.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!cpu_ready && !mem_req, "R10 reset outputs", {cpu_ready, mem_req}, 0);
        rst_n = 1;
        // R5: invalid ways fill first, way0 then way1
        access(0, mk(1, 2, 3), 0, "R5 fill way0");
        access(0, mk(1, 2, 5), 0, "R2 read hit");
        access(0, mk(2, 2, 0), 0, "R5 fill way1");
        access(0, mk(1, 2, 1), 0, "R4 touch way0");
        // R7: clean victim (way1, use clear) replaced without write-back
        access(0, mk(3, 2, 4), 0, "R7 clean evict");
        access(0, mk(1, 2, 6), 0, "R4 survivor hit");
        // R3: write hit, no memory traffic
        access(1, mk(1, 2, 0), 32'hDEAD_BEEF, "R3 write hit");
        access(0, mk(1, 2, 0), 0, "R3 read back");
        // R6: make dirty way0 the victim
        access(0, mk(3, 2, 2), 0, "R4 touch way1");
        access(0, mk(4, 2, 7), 0, "R6 dirty evict");
        access(0, mk(1, 2, 0), 0, "R6 data survives");
        // R8: write miss allocates, then later eviction writes it back
        access(1, mk(7, 5, 2), 32'h1234_5678, "R8 write miss");
        access(0, mk(7, 5, 2), 0, "R8 merged read");
        access(0, mk(8, 5, 0), 0, "R8 second way");
        access(0, mk(9, 5, 0), 0, "R8 evict dirty");
        access(0, mk(7, 5, 2), 0, "R8 value from memory");
        // Mixed run over contended sets
        for (int i = 0; i < 600; i++) begin
            int tg = $urandom_range(0, 3), st = $urandom_range(0, 1);
            int wd = $urandom_range(0, WORDS - 1);
            bit we = $urandom_range(0, 2) == 0;
            access(we, mk(tg, st, wd), $urandom, "R1/R4/R6 mixed");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule